// File: doc/BRIEF.md
# Virtually indexed, physically tagged cache lookup

This block answers load lookups for a two-way set-associative data cache. The set is picked from the low address bits, which lie inside the 4 KB page and are never changed by translation. So the tag and data arrays are read in the same cycle that a small fully associative TLB translates the upper bits of the address. The TLB delay therefore does not add to the cache access. In the following cycle the physical page number from the TLB is compared with the stored physical tags of both ways of the chosen set. That cycle reports one of three outcomes: a hit with its data word, a cache miss, or a TLB miss.

The surrounding logic loads translations through a TLB fill port and loads whole 32-byte lines through a line fill port. A flush input removes every translation at once, for example on a context switch. Cached lines stay valid across a flush because they carry physical tags, so a later refill of the TLB finds them again. Page-table walks, the path to memory and coherence are handled outside this block.

Top module: `vipt_lookup`

## Requirements
- R1: The set is address bits [11:5] and the byte offset is bits [4:0], all inside the page offset. Two virtual pages that map to the same physical page read the same cached line. Elaboration rejects any configuration whose set count times line size exceeds the page size.
- R2: A lookup presented with req_valid in cycle t is answered with resp_valid in cycle t+1, and only then. Each answer raises exactly one of resp_hit, resp_miss and resp_tlb_miss.
- R3: The TLB has 8 fully associative entries, matched on virtual page number bits [31:12]. When no valid entry matches, resp_tlb_miss is 1 and resp_hit is 0, whatever the cache holds.
- R4: A hit requires a TLB hit and a valid way of the set whose stored 20-bit physical page number equals the translated one. A TLB hit without such a way gives resp_miss.
- R5: On a hit, resp_data is bits [32k+31:32k] of the hitting line, where k is address bits [4:2]. resp_data is 0 when there is no hit.
- R6: A line fill writes the tag and the 256-bit line into set line_fill_set, in the way named by that set's LRU bit (0 after reset). It marks that way valid and then points the LRU bit at the other way.
- R7: A hit in way w sets the set's LRU bit to the other way, so the next fill of that set replaces the way that was not used.
- R8: Flush invalidates every TLB entry in one cycle, so a lookup issued in the next cycle reports a TLB miss. Flush wins over a TLB fill in the same cycle. Cache lines survive a flush and hit again once a matching translation is loaded.
- R9: A TLB fill uses the lowest-numbered invalid entry. When all entries are valid, it uses the entry named by a rotating pointer. The pointer is 0 after reset and advances by one, with wrap-around, only on such replacements.
- R10: Reset clears all TLB entries, all cache valid bits and all LRU bits, and holds every response output at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Invalidate all TLB entries |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address of the load |
| resp_valid | output | 1 | Answer present, one cycle after the request |
| resp_hit | output | 1 | Cache hit |
| resp_miss | output | 1 | Translated, but no matching valid way |
| resp_tlb_miss | output | 1 | No valid translation |
| resp_data | output | 32 | Selected word on a hit, otherwise 0 |
| tlb_fill_valid | input | 1 | Load a translation |
| tlb_fill_vpn | input | 20 | Virtual page number to load |
| tlb_fill_ppn | input | 20 | Physical page number to load |
| line_fill_valid | input | 1 | Load a cache line |
| line_fill_set | input | 7 | Set to fill |
| line_fill_ppn | input | 20 | Physical tag of the line |
| line_fill_data | input | 256 | Line contents, word 0 in the low bits |

## Verification
The checks assume that the TLB never holds two valid entries with the same virtual page number. The bench keeps to this by choosing a distinct page number for every translation it loads. They also assume that no fill touches the set being looked up in the same cycle, or in the cycle in which that lookup is answered. The bench keeps to this by running fills and lookups one at a time, each finished before the next starts. A reference model in the bench, built from the requirements, predicts every outcome. The stimulus sweeps all 128 sets and all eight word positions, then walks through TLB replacement, the LRU order and flush.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    // Default geometry of the lookup unit
    localparam int DEF_ADDR_W     = 32;
    localparam int DEF_PAGE_BYTES = 4096;
    localparam int DEF_LINE_BYTES = 32;
    localparam int DEF_NUM_SETS   = 128;
    localparam int DEF_TLB_SLOTS  = 8;
    localparam int WORD_W         = 32;
    localparam int NUM_WAYS       = 2;   // one LRU bit per set assumes two ways
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
    parameter int SLOTS = 8,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn
);
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } slot_t;

    typedef struct packed {
        slot_t [SLOTS-1:0] slot;
        logic  [PTR_W-1:0] ptr;
    } tlb_state_t;

    tlb_state_t st_d, st_q;
    logic [PTR_W-1:0] victim;
    logic             free_found;

    // Parallel compare against every entry
    always_comb begin
        lk_hit = 1'b0;
        lk_ppn = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (st_q.slot[i].vld && st_q.slot[i].vpn == lk_vpn) begin
                lk_hit = 1'b1;
                lk_ppn = lk_ppn | st_q.slot[i].ppn;
            end
        end
    end

    // Next state: flush, or fill into free slot / rotating victim
    always_comb begin
        st_d       = st_q;
        victim     = st_q.ptr;
        free_found = 1'b0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (!st_q.slot[i].vld) begin
                victim     = PTR_W'(i);
                free_found = 1'b1;
            end
        end
        if (flush) begin
            for (int i = 0; i < SLOTS; i++) begin
                st_d.slot[i].vld = 1'b0;
            end
        end else if (fill_en) begin
            st_d.slot[victim] = '{vld: 1'b1, vpn: fill_vpn, ppn: fill_ppn};
            if (!free_found) begin
                st_d.ptr = (st_q.ptr == PTR_W'(SLOTS - 1)) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/vipt_way_store.sv
module vipt_way_store #(
    parameter int IDX_W  = 7,
    parameter int TAG_W  = 20,
    parameter int LINE_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_set,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_set,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    output logic              rd_valid_q,
    output logic [TAG_W-1:0]  rd_tag_q,
    output logic [LINE_W-1:0] rd_line_q
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_d, valid_q;
    logic [TAG_W-1:0]  tag_mem  [SETS];
    logic [LINE_W-1:0] line_mem [SETS];

    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[wr_set] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q    <= '0;
            rd_valid_q <= 1'b0;
        end else begin
            valid_q    <= valid_d;
            rd_valid_q <= valid_q[rd_set];
        end
    end

    // Arrays without reset: synchronous read, write on fill
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_set]  <= wr_tag;
            line_mem[wr_set] <= wr_line;
        end
        rd_tag_q  <= tag_mem[rd_set];
        rd_line_q <= line_mem[rd_set];
    end
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_set,
    input  logic             touch_way,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_set,
    output logic             fill_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] lru_d, lru_q;

    assign fill_way = lru_q[fill_set];

    // A fill to the same set overrides a hit update
    always_comb begin
        lru_d = lru_q;
        if (touch_en) lru_d[touch_set] = ~touch_way;
        if (fill_en)  lru_d[fill_set]  = ~lru_q[fill_set];
    end

    always_ff @(posedge clk) begin
        if (rst) lru_q <= '0;
        else     lru_q <= lru_d;
    end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
    import vipt_pkg::*;
#(
    parameter int ADDR_W     = DEF_ADDR_W,
    parameter int PAGE_BYTES = DEF_PAGE_BYTES,
    parameter int LINE_BYTES = DEF_LINE_BYTES,
    parameter int NUM_SETS   = DEF_NUM_SETS,
    parameter int TLB_SLOTS  = DEF_TLB_SLOTS
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  flush,
    input  logic                                  req_valid,
    input  logic [ADDR_W-1:0]                     req_vaddr,
    output logic                                  resp_valid,
    output logic                                  resp_hit,
    output logic                                  resp_miss,
    output logic                                  resp_tlb_miss,
    output logic [WORD_W-1:0]                     resp_data,
    input  logic                                  tlb_fill_valid,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  tlb_fill_vpn,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  tlb_fill_ppn,
    input  logic                                  line_fill_valid,
    input  logic [$clog2(NUM_SETS)-1:0]           line_fill_set,
    input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0]  line_fill_ppn,
    input  logic [LINE_BYTES*8-1:0]               line_fill_data
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_SETS);
    localparam int PAGE_W = $clog2(PAGE_BYTES);
    localparam int VPN_W  = ADDR_W - PAGE_W;
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int WORDS  = LINE_W / WORD_W;
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BSEL_W = $clog2(WORD_W / 8);

    // Index and offset must fit in the untranslated page offset
    if (NUM_SETS * LINE_BYTES > PAGE_BYTES) begin : g_bad_geometry
        $error("vipt_lookup: sets times line size exceeds page size");
    end

    typedef struct packed {
        logic              vld;
        logic              tlb_hit;
        logic [VPN_W-1:0]  ppn;
        logic [IDX_W-1:0]  set;
        logic [WSEL_W-1:0] word;
    } stage_t;

    stage_t stg_d, stg_q;

    logic              lk_hit;
    logic [VPN_W-1:0]  lk_ppn;
    logic              rd_valid [NUM_WAYS];
    logic [VPN_W-1:0]  rd_tag   [NUM_WAYS];
    logic [LINE_W-1:0] rd_line  [NUM_WAYS];
    logic [NUM_WAYS-1:0] match;
    logic              hit_way;
    logic              fill_way;
    logic              unused_byte_sel;

    assign unused_byte_sel = ^req_vaddr[BSEL_W-1:0];

    vipt_tlb #(.SLOTS(TLB_SLOTS), .VPN_W(VPN_W), .PPN_W(VPN_W)) u_tlb (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .fill_en  (tlb_fill_valid),
        .fill_vpn (tlb_fill_vpn),
        .fill_ppn (tlb_fill_ppn),
        .lk_vpn   (req_vaddr[ADDR_W-1:PAGE_W]),
        .lk_hit   (lk_hit),
        .lk_ppn   (lk_ppn)
    );

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        vipt_way_store #(.IDX_W(IDX_W), .TAG_W(VPN_W), .LINE_W(LINE_W)) u_store (
            .clk        (clk),
            .rst        (rst),
            .rd_set     (req_vaddr[OFF_W +: IDX_W]),
            .wr_en      (line_fill_valid && (fill_way == 1'(w))),
            .wr_set     (line_fill_set),
            .wr_tag     (line_fill_ppn),
            .wr_line    (line_fill_data),
            .rd_valid_q (rd_valid[w]),
            .rd_tag_q   (rd_tag[w]),
            .rd_line_q  (rd_line[w])
        );
    end

    vipt_lru #(.IDX_W(IDX_W)) u_lru (
        .clk       (clk),
        .rst       (rst),
        .touch_en  (resp_hit),
        .touch_set (stg_q.set),
        .touch_way (hit_way),
        .fill_en   (line_fill_valid),
        .fill_set  (line_fill_set),
        .fill_way  (fill_way)
    );

    // Stage register: translation result captured with the set read
    always_comb begin
        stg_d.vld     = req_valid;
        stg_d.tlb_hit = lk_hit;
        stg_d.ppn     = lk_ppn;
        stg_d.set     = req_vaddr[OFF_W +: IDX_W];
        stg_d.word    = req_vaddr[BSEL_W +: WSEL_W];
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= stg_d;
    end

    // Physical tag compare and word select
    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) begin
            match[w] = stg_q.tlb_hit && rd_valid[w] && (rd_tag[w] == stg_q.ppn);
        end
        hit_way       = match[1];
        resp_valid    = stg_q.vld;
        resp_hit      = stg_q.vld && (|match);
        resp_miss     = stg_q.vld && stg_q.tlb_hit && !(|match);
        resp_tlb_miss = stg_q.vld && !stg_q.tlb_hit;
        resp_data     = resp_hit ? rd_line[hit_way][stg_q.word*WORD_W +: WORD_W] : '0;
    end
endmodule

// File: rtl/vipt_lookup_chk.sv
module vipt_lookup_chk (
    input logic clk,
    input logic rst,
    input logic flush,
    input logic req_valid,
    input logic resp_valid,
    input logic resp_hit,
    input logic resp_miss,
    input logic resp_tlb_miss
);
    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);

    // R2
    resp_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $past(req_valid));

    // R2
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> $onehot({resp_hit, resp_miss, resp_tlb_miss}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !resp_valid |-> !(resp_hit || resp_miss || resp_tlb_miss));

    // R8
    flush_drops_chk: assert property (@(posedge clk) disable iff (rst)
        flush ##1 req_valid |=> resp_tlb_miss);
endmodule

bind vipt_lookup vipt_lookup_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .flush         (flush),
    .req_valid     (req_valid),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .resp_miss     (resp_miss),
    .resp_tlb_miss (resp_tlb_miss)
);

// File: tb/vipt_lookup_test.sv
`timescale 1ns/1ps
module vipt_lookup_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         flush = 1'b0;
    logic         req_valid = 1'b0;
    logic [31:0]  req_vaddr = '0;
    logic         resp_valid, resp_hit, resp_miss, resp_tlb_miss;
    logic [31:0]  resp_data;
    logic         tlb_fill_valid = 1'b0;
    logic [19:0]  tlb_fill_vpn = '0;
    logic [19:0]  tlb_fill_ppn = '0;
    logic         line_fill_valid = 1'b0;
    logic [6:0]   line_fill_set = '0;
    logic [19:0]  line_fill_ppn = '0;
    logic [255:0] line_fill_data = '0;

    always #2.5 clk = ~clk;

    vipt_lookup uut (
        .clk(clk), .rst(rst), .flush(flush),
        .req_valid(req_valid), .req_vaddr(req_vaddr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_miss(resp_miss),
        .resp_tlb_miss(resp_tlb_miss), .resp_data(resp_data),
        .tlb_fill_valid(tlb_fill_valid), .tlb_fill_vpn(tlb_fill_vpn),
        .tlb_fill_ppn(tlb_fill_ppn),
        .line_fill_valid(line_fill_valid), .line_fill_set(line_fill_set),
        .line_fill_ppn(line_fill_ppn), .line_fill_data(line_fill_data)
    );

    // Reference model built from the requirements
    logic         m_tv   [8];
    logic [19:0]  m_tvpn [8];
    logic [19:0]  m_tppn [8];
    int           m_ptr;
    logic         m_cv   [128][2];
    logic [19:0]  m_ctag [128][2];
    logic [255:0] m_cline[128][2];
    logic         m_lru  [128];

    int checks = 0;
    int errors = 0;

    task automatic check(input logic ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [255:0] mk_line(input int seed);
        logic [255:0] l;
        for (int k = 0; k < 8; k++) begin
            l[k*32 +: 32] = 32'(seed * 40503 + k * 977) ^ 32'hC3A50000;
        end
        return l;
    endfunction

    function automatic logic [31:0] va(input logic [19:0] vpn, input int set, input int word);
        return {vpn, 7'(set), 3'(word), 2'b00};
    endfunction

    task automatic lookup(input logic [31:0] a, input string req);
        logic        th = 1'b0;
        logic [19:0] pp = '0;
        logic        eh = 1'b0;
        logic        ew = 1'b0;
        logic [31:0] ed = '0;
        int          s = int'(a[11:5]);
        int          k = int'(a[4:2]);
        for (int i = 0; i < 8; i++) begin
            if (m_tv[i] && m_tvpn[i] == a[31:12]) begin
                th = 1'b1;
                pp = m_tppn[i];
            end
        end
        if (th) begin
            for (int w = 0; w < 2; w++) begin
                if (m_cv[s][w] && m_ctag[s][w] == pp) begin
                    eh = 1'b1;
                    ew = 1'(w);
                end
            end
        end
        if (eh) ed = m_cline[s][ew][k*32 +: 32];
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = a;
        @(negedge clk);
        req_valid = 1'b0;
        check({resp_valid, resp_hit, resp_miss, resp_tlb_miss, resp_data} ==
              {1'b1, eh, th && !eh, !th, ed}, req, "lookup",
              {28'd0, resp_valid, resp_hit, resp_miss, resp_tlb_miss, resp_data},
              {28'd0, 1'b1, eh, th && !eh, !th, ed});
        if (eh) m_lru[s] = ~ew;
    endtask

    task automatic tfill(input logic [19:0] vpn, input logic [19:0] ppn);
        int v = -1;
        for (int i = 7; i >= 0; i--) if (!m_tv[i]) v = i;
        if (v < 0) begin
            v = m_ptr;
            m_ptr = (m_ptr + 1) % 8;
        end
        m_tv[v] = 1'b1;
        m_tvpn[v] = vpn;
        m_tppn[v] = ppn;
        @(negedge clk);
        tlb_fill_valid = 1'b1;
        tlb_fill_vpn = vpn;
        tlb_fill_ppn = ppn;
        @(negedge clk);
        tlb_fill_valid = 1'b0;
    endtask

    task automatic lfill(input int s, input logic [19:0] ppn, input logic [255:0] line);
        logic w = m_lru[s];
        m_cv[s][w] = 1'b1;
        m_ctag[s][w] = ppn;
        m_cline[s][w] = line;
        m_lru[s] = ~w;
        @(negedge clk);
        line_fill_valid = 1'b1;
        line_fill_set = 7'(s);
        line_fill_ppn = ppn;
        line_fill_data = line;
        @(negedge clk);
        line_fill_valid = 1'b0;
    endtask

    task automatic do_flush(input logic with_fill);
        for (int i = 0; i < 8; i++) m_tv[i] = 1'b0;
        @(negedge clk);
        flush = 1'b1;
        tlb_fill_valid = with_fill;
        tlb_fill_vpn = 20'h3FFFF;
        tlb_fill_ppn = 20'h80000;
        @(negedge clk);
        flush = 1'b0;
        tlb_fill_valid = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        m_ptr = 0;
        for (int i = 0; i < 8; i++) begin
            m_tv[i] = 1'b0; m_tvpn[i] = '0; m_tppn[i] = '0;
        end
        for (int s = 0; s < 128; s++) begin
            m_lru[s] = 1'b0;
            for (int w = 0; w < 2; w++) begin
                m_cv[s][w] = 1'b0; m_ctag[s][w] = '0; m_cline[s][w] = '0;
            end
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: idle outputs after reset
        check({resp_valid, resp_hit, resp_miss, resp_tlb_miss, resp_data} == '0,
              "R10", "idle", {28'd0, resp_valid, resp_hit, resp_miss, resp_tlb_miss, resp_data}, 0);
        lookup(va(20'h10000, 2, 0), "R10");
        lookup(va(20'hABCDE, 127, 7), "R3");

        for (int i = 0; i < 8; i++) tfill(20'h10000 + 20'(i), 20'h80000 + 20'(i));
        lookup(va(20'h10000, 3, 0), "R4");
        @(negedge clk);
        // R2: answer lasts only one cycle
        check(resp_valid == 1'b0, "R2", "resp_valid drop", {63'd0, resp_valid}, 0);

        // R5/R6 sweep over all sets and word positions
        for (int s = 0; s < 128; s++) begin
            lfill(s, 20'h80000, mk_line(s));
            lfill(s, 20'h80001, mk_line(s + 1000));
            for (int k = 0; k < 8; k++) lookup(va(20'h10000, s, k), "R5");
            for (int k = 0; k < 8; k++) lookup(va(20'h10001, s, k), "R6");
        end

        // R7: hit on way 0 protects it from the next fill
        lookup(va(20'h10000, 9, 1), "R7");
        lfill(9, 20'h80002, mk_line(5000));
        lookup(va(20'h10001, 9, 1), "R7");
        lookup(va(20'h10000, 9, 2), "R7");
        lookup(va(20'h10002, 9, 3), "R6");
        // R6: untouched set replaces way 0 first
        lfill(10, 20'h80003, mk_line(6000));
        lookup(va(20'h10000, 10, 0), "R6");
        lookup(va(20'h10001, 10, 4), "R6");
        lookup(va(20'h10003, 10, 6), "R6");

        // R9: full TLB replaces entry 0 then entry 1; R1 synonym
        tfill(20'h20000, 20'h80000);
        lookup(va(20'h10000, 3, 0), "R9");
        lookup(va(20'h20000, 3, 5), "R1");
        lookup(va(20'h10001, 3, 5), "R9");
        tfill(20'h20001, 20'h90000);
        lookup(va(20'h20001, 4, 0), "R4");
        lookup(va(20'h10001, 4, 0), "R9");
        lookup(va(20'h10002, 4, 0), "R9");

        // R8: flush drops translations, keeps lines; wins over same-cycle fill
        do_flush(1'b1);
        lookup(va(20'h3FFFF, 0, 0), "R8");
        lookup(va(20'h20000, 3, 5), "R8");
        lookup(va(20'h10002, 9, 3), "R8");
        tfill(20'h30000, 20'h80001);
        for (int s = 0; s < 128; s++) lookup(va(20'h30000, s, 7), "R8");
        tfill(20'h30001, 20'h80000);
        for (int s = 0; s < 128; s += 9) lookup(va(20'h30001, s, s % 8), "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule